// File: doc/BRIEF.md
# Raster-Synchronised Background Line Fetcher

This block feeds a display pipeline with background pixels taken from memory that returns very wide words, by default 3072 bits carrying 96 pixels of 32 bits each. Its work is paced by two raster strobes. A frame strobe arrives during vertical blanking. The block latches the frame's configuration on that strobe, then requests every word of display line 0, so that the first line is ready before it is shown. After that, each line strobe does two things. It starts the pixel drain of the current line, and it requests every word of the following line. This keeps exactly one line of fetch ahead of the beam.

Returned words enter a two-word buffer, which holds the data back with a ready signal when it is full. An unpacker then issues one pixel per display request, taking pixels in ascending order within each word. The number of words per line is the line width divided by the pixels per word, rounded up. When the width is not a whole number of words, the unused pixels at the end of the last word are thrown away when that word leaves the buffer. This happens at the end of the line, during horizontal blanking, so the next line always starts on a fresh word. If a pixel is requested while the buffer is empty, the block raises an underrun flag.

Top module: `bgf_line_fetch`

## Requirements
- R1: After reset, no read command and no pixel is presented, the underrun flag is low, and read data is accepted (ready high).
- R2: One cycle after a frame strobe, the block issues ceil(width/96) read commands for line 0. Their addresses are base, base+1, and so on, all taken before the first line strobe.
- R3: A line strobe for line L (counting from 0) starts the read commands for line L+1. The addresses are base + (L+1)*stride + w, for w from 0 to ceil(width/96)-1. No commands are issued when L+1 is not less than the line count.
- R4: A pixel request inside an active line yields a valid pixel one cycle later. Pixel j of the line is the 32-bit field at bit offset (j mod 96)*32 of the line's word number floor(j/96).
- R5: Each line yields exactly `width` pixels. A pixel request after the last pixel of the line gives no pixel and no underrun.
- R6: On a width that is not a multiple of 96, the surplus pixels of the last word are dropped. The next line begins with pixel 0 of its own first word, and no word is left in the buffer after the frame.
- R7: A pixel request inside an active line while the buffer is empty raises the underrun flag for one cycle, with no valid pixel. The line position does not advance, so the next served pixel is the one that was missed.
- R8: The buffer holds at most two words. Read-data ready is low while two words are held, and a pending word stays unaccepted.
- R9: Base, stride, width and line count are sampled only on the frame strobe. Changes to them during the frame affect neither addresses nor pixel counts.
- R10: A read command that is not accepted keeps its address unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame strobe, given in vertical blanking |
| line_start | input | 1 | Strobe at the start of each displayed line |
| cfg_base | input | 32 | Word address of line 0 |
| cfg_stride | input | 32 | Word distance between consecutive lines |
| cfg_width | input | 12 | Pixels per line |
| cfg_lines | input | 12 | Lines per frame |
| rd_cmd_valid | output | 1 | Read command present |
| rd_cmd_ready | input | 1 | Memory accepts the command |
| rd_cmd_addr | output | 32 | Word address of the command |
| rd_data_valid | input | 1 | Returned word present |
| rd_data_ready | output | 1 | Buffer can take a word |
| rd_data | input | WORD_W | Returned wide word |
| pix_req | input | 1 | Display asks for the next pixel |
| pix_valid | output | 1 | Pixel output valid |
| pix_data | output | PIX_W | Pixel value |
| underrun | output | 1 | Pixel was asked for with an empty buffer |

## Verification
The main stimulus is a set of frames with different widths. Aligned widths (192) show that the word is popped on the last pixel. A width of 200 shows the drop of the last word's surplus pixels. A width of 97 leaves one pixel in its last word, which stresses the pop at the same time as the line ends, and random widths from 1 to 300 cover other values. The memory model returns words with random latency and random command acceptance, and each word holds values built from its address and lane. A wrong address, a wrong lane order or a lost word therefore each show up as a distinct mismatch. One frame changes the configuration inputs after the frame strobe, which separates latched from live configuration. A stalled-memory frame forces an underrun and then shows that the missed pixel is the one served next, and also that the buffer holds back at two words.

// File: rtl/bgf_pkg.sv
package bgf_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 12;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] stride;
        logic [CNT_W-1:0]  width;
        logic [CNT_W-1:0]  lines;
    } fetch_cfg_t;

    // words needed to cover n pixels at d pixels per word
    function automatic logic [CNT_W-1:0] ceil_div(input logic [CNT_W-1:0] n, input int unsigned d);
        int unsigned q;
        q = (32'(n) + d - 1) / d;
        return CNT_W'(q);
    endfunction

endpackage

// File: rtl/bgf_cmd_gen.sv
module bgf_cmd_gen
    import bgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prime,
    input  logic              line_start,
    input  fetch_cfg_t        cfg,
    input  logic [CNT_W-1:0]  wpl,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr
);

    logic [CNT_W-1:0]  next_line_q;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_line_q <= '0;
            left_q      <= '0;
            addr_q      <= '0;
        end else if (prime) begin
            next_line_q <= CNT_W'(1);
            left_q      <= (cfg.lines != '0) ? wpl : '0;
            addr_q      <= cfg.base;
        end else if (line_start) begin
            if (next_line_q < cfg.lines) begin
                addr_q      <= cfg.base + ADDR_W'(next_line_q) * cfg.stride;
                left_q      <= wpl;
                next_line_q <= next_line_q + CNT_W'(1);
            end
        end else if (cmd_valid && cmd_ready) begin
            addr_q <= addr_q + ADDR_W'(1);
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign cmd_valid = (left_q != '0);
    assign cmd_addr  = addr_q;

endmodule

// File: rtl/bgf_word_fifo.sv
module bgf_word_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [OCC_W-1:0] occ_q;
    logic             do_push, do_pop;

    assign full    = (occ_q == OCC_W'(DEPTH));
    assign empty   = (occ_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = store[rd_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) store[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            occ_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            case ({do_push, do_pop})
                2'b10:   occ_q <= occ_q + OCC_W'(1);
                2'b01:   occ_q <= occ_q - OCC_W'(1);
                default: occ_q <= occ_q;
            endcase
        end
    end

endmodule

// File: rtl/bgf_unpack.sv
module bgf_unpack
    import bgf_pkg::*;
#(
    parameter int WORD_W = 3072,
    parameter int PIX_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic [CNT_W-1:0]  width,
    input  logic              pix_req,
    input  logic [WORD_W-1:0] head,
    input  logic              empty,
    output logic              pop,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    output logic              underrun
);

    localparam int PPW   = WORD_W / PIX_W;
    localparam int IDX_W = (PPW > 1) ? $clog2(PPW) : 1;

    logic [PIX_W-1:0] lane [PPW];

    generate
        for (genvar g = 0; g < PPW; g++) begin : g_lane
            assign lane[g] = head[g*PIX_W +: PIX_W];
        end
    endgenerate

    logic [CNT_W-1:0] left_q;
    logic [IDX_W-1:0] idx_q;
    logic             in_line, take, last_lane, last_pix;

    assign in_line   = (left_q != '0);
    assign take      = pix_req && in_line && !empty;
    assign last_lane = (idx_q == IDX_W'(PPW - 1));
    assign last_pix  = (left_q == CNT_W'(1));
    // the last word of a line leaves with its unused lanes
    assign pop       = take && (last_lane || last_pix);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q    <= '0;
            idx_q     <= '0;
            pix_valid <= 1'b0;
            pix_data  <= '0;
            underrun  <= 1'b0;
        end else begin
            pix_valid <= take;
            underrun  <= pix_req && in_line && empty;
            if (take) pix_data <= lane[idx_q];
            if (line_start) begin
                left_q <= width;
                idx_q  <= '0;
            end else if (take) begin
                left_q <= left_q - CNT_W'(1);
                idx_q  <= pop ? '0 : idx_q + IDX_W'(1);
            end
        end
    end

endmodule

// File: rtl/bgf_line_fetch.sv
module bgf_line_fetch
    import bgf_pkg::*;
#(
    parameter int WORD_W    = 3072,
    parameter int PIX_W     = 32,
    parameter int BUF_WORDS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic [31:0]       cfg_base,
    input  logic [31:0]       cfg_stride,
    input  logic [11:0]       cfg_width,
    input  logic [11:0]       cfg_lines,
    output logic              rd_cmd_valid,
    input  logic              rd_cmd_ready,
    output logic [31:0]       rd_cmd_addr,
    input  logic              rd_data_valid,
    output logic              rd_data_ready,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              pix_req,
    output logic              pix_valid,
    output logic [PIX_W-1:0]  pix_data,
    output logic              underrun
);

    localparam int PPW = WORD_W / PIX_W;

    fetch_cfg_t        cfg_q;
    logic              prime_q;
    logic [CNT_W-1:0]  wpl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            prime_q <= 1'b0;
            wpl_q   <= '0;
        end else begin
            prime_q <= frame_start;
            if (frame_start) begin
                cfg_q <= '{base: cfg_base, stride: cfg_stride, width: cfg_width, lines: cfg_lines};
                wpl_q <= ceil_div(cfg_width, PPW);
            end
        end
    end

    bgf_cmd_gen u_cmd (
        .clk        (clk),
        .rst        (rst),
        .prime      (prime_q),
        .line_start (line_start),
        .cfg        (cfg_q),
        .wpl        (wpl_q),
        .cmd_valid  (rd_cmd_valid),
        .cmd_ready  (rd_cmd_ready),
        .cmd_addr   (rd_cmd_addr)
    );

    logic              buf_full, buf_empty, buf_pop;
    logic [WORD_W-1:0] buf_head;

    assign rd_data_ready = !buf_full;

    bgf_word_fifo #(.W(WORD_W), .DEPTH(BUF_WORDS)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .push  (rd_data_valid),
        .din   (rd_data),
        .pop   (buf_pop),
        .dout  (buf_head),
        .full  (buf_full),
        .empty (buf_empty)
    );

    bgf_unpack #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_unpack (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .width      (cfg_q.width),
        .pix_req    (pix_req),
        .head       (buf_head),
        .empty      (buf_empty),
        .pop        (buf_pop),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .underrun   (underrun)
    );

endmodule

// File: rtl/bgf_line_fetch_chk.sv
module bgf_line_fetch_chk (
    input logic        clk,
    input logic        rst,
    input logic        frame_start,
    input logic        line_start,
    input logic        rd_cmd_valid,
    input logic        rd_cmd_ready,
    input logic [31:0] rd_cmd_addr,
    input logic        rd_data_valid,
    input logic        rd_data_ready,
    input logic        pix_req,
    input logic        pix_valid,
    input logic        underrun
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !rd_cmd_valid && !pix_valid && !underrun);

    // R10
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_cmd_valid && !rd_cmd_ready && !line_start && !$past(frame_start)
        |=> rd_cmd_valid && $stable(rd_cmd_addr));

    // R2 R3
    cmd_trigger_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_cmd_valid) |-> $past(line_start) || $past(frame_start, 2));

    // R5
    req_cause_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(pix_req));

    // R7
    underrun_excl_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |-> !pix_valid && $past(pix_req));

    // R8
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data_ready) |-> $past(rd_data_valid));

endmodule

bind bgf_line_fetch bgf_line_fetch_chk chk_i (.*);

// File: tb/bgf_line_fetch_tb_top.sv
`timescale 1ns/1ps
module bgf_line_fetch_tb_top;

    localparam int WORD_W = 3072;
    localparam int PIX_W  = 32;
    localparam int PPW    = WORD_W / PIX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0, line_start = 1'b0, pix_req = 1'b0;
    logic [31:0]       cfg_base = '0, cfg_stride = '0;
    logic [11:0]       cfg_width = '0, cfg_lines = '0;
    logic              rd_cmd_valid, rd_cmd_ready = 1'b0;
    logic [31:0]       rd_cmd_addr;
    logic              rd_data_valid = 1'b0, rd_data_ready;
    logic [WORD_W-1:0] rd_data = '0;
    logic              pix_valid, underrun;
    logic [PIX_W-1:0]  pix_data;

    always #4 clk = ~clk;

    bgf_line_fetch dut_i (.*);

    int checks = 0, errors = 0;
    bit done = 1'b0;

    int unsigned f_base, f_stride, f_width, f_lines, f_wpl;
    int unsigned cmd_n, got_pix, cur_line, under_cnt;
    bit          allow_under = 1'b0, mem_stall = 1'b0;
    int unsigned mq[$];
    int unsigned dly;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_pix(input logic [31:0] addr, input int unsigned lane);
        return {addr[23:0], 8'(lane)};
    endfunction

    function automatic logic [WORD_W-1:0] mkword(input logic [31:0] addr);
        logic [WORD_W-1:0] w;
        for (int k = 0; k < PPW; k++) w[k*PIX_W +: PIX_W] = exp_pix(addr, k);
        return w;
    endfunction

    // memory model: random acceptance and random return latency
    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            rd_data_valid <= 1'b0;
            rd_cmd_ready  <= 1'b0;
            dly           <= 0;
        end else begin
            if (rd_cmd_valid && rd_cmd_ready) begin
                int unsigned ln, wd;
                ln = cmd_n / f_wpl;
                wd = cmd_n % f_wpl;
                chk(cmd_n < f_lines * f_wpl, "R3", "command beyond last line", cmd_n, f_lines * f_wpl);
                chk(rd_cmd_addr == f_base + ln * f_stride + wd, (ln == 0) ? "R2" : "R3",
                    "command address", rd_cmd_addr, f_base + ln * f_stride + wd);
                mq.push_back(rd_cmd_addr);
                cmd_n++;
            end
            if (rd_data_valid && rd_data_ready) begin
                void'(mq.pop_front());
                rd_data_valid <= 1'b0;
                dly <= $urandom % 8;
            end else if (!rd_data_valid && mq.size() > 0 && !mem_stall) begin
                if (dly == 0) begin
                    rd_data_valid <= 1'b1;
                    rd_data       <= mkword(mq[0]);
                end else begin
                    dly <= dly - 1;
                end
            end
            rd_cmd_ready <= ($urandom % 4) != 0;
        end
    end

    // pixel monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (pix_valid) begin
                int unsigned w, k;
                logic [31:0] a;
                w = got_pix / PPW;
                k = got_pix % PPW;
                a = f_base + cur_line * f_stride + w;
                chk(pix_data == exp_pix(a, k),
                    (cur_line > 0 && (f_width % PPW) != 0) ? "R6" : "R4",
                    "pixel value", pix_data, exp_pix(a, k));
                got_pix++;
            end
            if (underrun) begin
                under_cnt++;
                if (!allow_under) chk(1'b0, "R7", "unexpected underrun", 1, 0);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic start_frame(input int unsigned base, stride, width, lines);
        f_base = base; f_stride = stride; f_width = width; f_lines = lines;
        f_wpl = (width + PPW - 1) / PPW;
        cmd_n = 0;
        cfg_base = base; cfg_stride = stride; cfg_width = 12'(width); cfg_lines = 12'(lines);
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic run_frame(input int unsigned base, stride, width, lines, input bit scramble);
        start_frame(base, stride, width, lines);
        if (scramble) begin
            cfg_base = ~base; cfg_stride = stride + 3;
            cfg_width = 12'(width + 5); cfg_lines = 12'(lines + 2);
        end
        repeat (40) tick();
        for (int l = 0; l < int'(lines); l++) begin
            cur_line = l; got_pix = 0;
            line_start = 1'b1;
            tick();
            line_start = 1'b0;
            pix_req = 1'b1;
            repeat (width + 6) tick();
            pix_req = 1'b0;
            repeat (30) tick();
            chk(got_pix == width, scramble ? "R9" : "R5", "pixels in line", got_pix, width);
        end
        repeat (10) tick();
        chk(cmd_n == lines * f_wpl, scramble ? "R9" : "R3", "commands in frame", cmd_n, lines * f_wpl);
        chk(rd_data_ready == 1'b1 && mq.size() == 0, "R6", "buffer drained after frame",
            rd_data_ready, 1);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) tick();
        rst = 1'b0;
        @(negedge clk);
        chk(rd_cmd_valid == 1'b0, "R1", "cmd valid after reset", rd_cmd_valid, 0);
        chk(pix_valid == 1'b0, "R1", "pixel valid after reset", pix_valid, 0);
        chk(underrun == 1'b0, "R1", "underrun after reset", underrun, 0);
        chk(rd_data_ready == 1'b1, "R1", "data ready after reset", rd_data_ready, 1);
        tick();

        run_frame(32'h1000, 2, 192, 3, 1'b0);   // aligned width
        run_frame(32'h2000, 5, 200, 3, 1'b0);   // R6 surplus lanes
        run_frame(32'h3000, 3, 97, 2, 1'b1);    // R9 config changed mid-frame
        for (int i = 0; i < 3; i++) begin
            int unsigned w, wp;
            w  = 1 + $urandom % 300;
            wp = (w + PPW - 1) / PPW;
            run_frame($urandom % 32'h10_0000, wp + $urandom % 4, w, 1 + $urandom % 4, 1'b0);
        end

        // R7 R8: stalled memory
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        mem_stall = 1'b1;
        under_cnt = 0;
        start_frame(32'h40, 4, 200, 1);
        repeat (40) tick();
        cur_line = 0; got_pix = 0; allow_under = 1'b1;
        line_start = 1'b1;
        tick();
        line_start = 1'b0;
        pix_req = 1'b1;
        tick();
        pix_req = 1'b0;
        tick();
        chk(underrun == 1'b0 && under_cnt == 1, "R7", "underrun one-cycle pulse", under_cnt, 1);
        chk(got_pix == 0, "R7", "no pixel on underrun", got_pix, 0);
        mem_stall = 1'b0;
        repeat (40) tick();
        chk(rd_data_ready == 1'b0, "R8", "ready with two words held", rd_data_ready, 0);
        chk(rd_data_valid == 1'b1, "R8", "third word kept pending", rd_data_valid, 1);
        allow_under = 1'b0;
        pix_req = 1'b1;
        repeat (206) tick();
        pix_req = 1'b0;
        repeat (10) tick();
        chk(got_pix == 200, "R7", "line completes after underrun", got_pix, 200);
        chk(under_cnt == 1, "R7", "underrun count", under_cnt, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule